// File: doc/BRIEF.md
# Load/Store Execution Unit with Byte-Granular Data Memory

This block carries out the memory instructions of a 64-bit integer pipeline against a private, byte-addressed data store. Each request presents a 32-bit instruction word, the value of the base register and the value to be stored. The unit decodes the operation class from the opcode. It rebuilds the signed offset from the field layout that class uses and adds it to the base to form the target address. It then reads or writes 1, 2, 4 or 8 bytes.

Loads return a 64-bit result one cycle after the request, with the destination register index and a valid strobe. Whether a narrow result is sign-extended or zero-extended follows from the width code. Stores update memory at the request's clock edge and return nothing. Width codes with no meaning for their class do no access and raise a one-cycle illegal flag instead. The memory size is a parameter and must be a power of two of at least 8 bytes. Addresses wrap modulo that size, and the unit never checks alignment.

Top module: `lsu_mem`

## Requirements
- R1: A load (opcode 0x03) takes instruction bits 31:20 as a 12-bit two's complement offset; the target address is the base plus that offset sign-extended to 64 bits.
- R2: A store (opcode 0x23) builds its 12-bit two's complement offset with instruction bits 31:25 as offset bits 11:5 and instruction bits 11:7 as offset bits 4:0. The target address is the base plus that offset sign-extended.
- R3: Width code (instruction bits 14:12) 0, 1 and 2 on a load read 1, 2 and 4 bytes, sign-extended from their top bit to 64 bits; code 3 reads 8 bytes.
- R4: Width codes 4, 5 and 6 on a load read 1, 2 and 4 bytes and zero-extend them to 64 bits.
- R5: Width codes 0 to 3 on a store write the low 1, 2, 4 or 8 bytes of the store data starting at the target address; every other memory byte keeps its value.
- R6: Memory is little-endian: byte k of a value (k=0 least significant) lives at target address + k.
- R7: A legal load drives the valid strobe high for exactly one cycle, in the cycle after the request, with the result and the index from instruction bits 11:7. Stores, other opcodes and idle cycles never raise the strobe.
- R8: A load with width code 7, or a store with width code 4 to 7, accesses nothing. It raises the illegal flag for one cycle in the cycle after the request, and the valid strobe stays low.
- R9: Byte addresses are taken modulo the memory size, so an access that runs past the top continues at address 0 and high base bits are ignored.
- R10: During and after reset the valid strobe and illegal flag are low, and every memory byte reads back as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| instr | input | 32 | Instruction word of the request |
| base | input | 64 | Base register value |
| wdata | input | 64 | Store data value |
| rd_valid | output | 1 | Load result valid |
| rd_idx | output | 5 | Destination register index of the result |
| rd_data | output | 64 | Extended load result |
| illegal | output | 1 | Illegal width code seen on previous request |

## Verification
A store that lands on the wrong bytes or writes too many lanes stays hidden until a later load covers those addresses. The bench therefore reads every store back with wide loads and narrow loads, including across the wrap point, so corrupted neighbours appear in the result one cycle after that load. An extension or width error shows directly in the upper bits of the next result. A wrong strobe or flag, or a lost or extra one, shows as a scoreboard entry that is missing or unexpected in the cycle right after the request.

// File: rtl/lsu_mem.sv
module lsu_mem #(
  parameter int MEM_BYTES = 256,
  parameter int XLEN      = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] wdata,
  output logic            rd_valid,
  output logic [4:0]      rd_idx,
  output logic [XLEN-1:0] rd_data,
  output logic            illegal
);
  localparam int AW    = $clog2(MEM_BYTES);
  localparam int LANES = XLEN / 8;
  localparam logic [6:0] OP_LOAD  = 7'h03;
  localparam logic [6:0] OP_STORE = 7'h23;

  logic [7:0] mem [MEM_BYTES];

  wire [6:0] opcode = instr[6:0];
  wire [2:0] wcode  = instr[14:12];
  wire is_ld = req_valid && opcode == OP_LOAD;
  wire is_st = req_valid && opcode == OP_STORE;
  wire ld_ok = is_ld && wcode != 3'd7;
  wire st_ok = is_st && !wcode[2];
  wire bad   = (is_ld && wcode == 3'd7) || (is_st && wcode[2]);

  wire [11:0] off_i = instr[31:20];
  wire [11:0] off_s = {instr[31:25], instr[11:7]};
  wire [11:0] off   = is_st ? off_s : off_i;
  wire [XLEN-1:0] target = base + {{(XLEN-12){off[11]}}, off};
  wire [AW-1:0] addr = target[AW-1:0];

  logic [AW-1:0]   lane_addr [LANES];
  logic [LANES-1:0] lane_en;
  logic [XLEN-1:0] raw;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      lane_addr[i] = addr + AW'(i);
      lane_en[i]   = i < (1 << wcode[1:0]);
      raw[8*i +: 8] = mem[lane_addr[i]];
    end
  end

  logic [XLEN-1:0] ext;
  always_comb begin
    case (wcode)
      3'd0:    ext = {{(XLEN-8){raw[7]}}, raw[7:0]};
      3'd1:    ext = {{(XLEN-16){raw[15]}}, raw[15:0]};
      3'd2:    ext = {{(XLEN-32){raw[31]}}, raw[31:0]};
      3'd4:    ext = {{(XLEN-8){1'b0}}, raw[7:0]};
      3'd5:    ext = {{(XLEN-16){1'b0}}, raw[15:0]};
      3'd6:    ext = {{(XLEN-32){1'b0}}, raw[31:0]};
      default: ext = raw;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < MEM_BYTES; a++) mem[a] <= '0;
    end else if (st_ok) begin
      for (int i = 0; i < LANES; i++)
        if (lane_en[i]) mem[lane_addr[i]] <= wdata[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      illegal  <= 1'b0;
      rd_idx   <= '0;
      rd_data  <= '0;
    end else begin
      rd_valid <= ld_ok;
      illegal  <= bad;
      if (ld_ok) begin
        rd_idx  <= instr[11:7];
        rd_data <= ext;
      end
    end
  end
endmodule

// File: rtl/lsu_mem_chk.sv
module lsu_mem_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] instr,
  input logic        rd_valid,
  input logic [4:0]  rd_idx,
  input logic [63:0] rd_data,
  input logic        illegal
);
  wire ld  = req_valid && instr[6:0] == 7'h03;
  wire st  = req_valid && instr[6:0] == 7'h23;

  p_load_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && instr[14:12] != 3'd7) |=> (rd_valid && !illegal));
  p_load_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && instr[14:12] != 3'd7) |=> rd_idx == $past(instr[11:7]));
  p_no_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> !rd_valid);
  p_bad_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && instr[14:12] == 3'd7) |=> (illegal && !rd_valid));
  p_bad_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st && instr[14]) |=> illegal);
  p_flag_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld && instr[14:12] == 3'd7) && !(st && instr[14]) |=> !illegal);
  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_valid, illegal}));
  p_sign_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && instr[14:12] == 3'd0) |=> rd_data[63:8] == {56{rd_data[7]}});
  p_zero_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && instr[14:12] == 3'd5) |=> rd_data[63:16] == '0);
endmodule

bind lsu_mem lsu_mem_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .instr(instr),
  .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_data(rd_data), .illegal(illegal)
);

// File: tb/tb_lsu_mem.sv
`timescale 1ns/1ps
module tb_lsu_mem;
  localparam int MB = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] base = '0, wdata = '0;
  logic rd_valid, illegal;
  logic [4:0] rd_idx;
  logic [63:0] rd_data;

  lsu_mem #(.MEM_BYTES(MB)) dut (.*);

  always #2.5 clk = ~clk;

  typedef struct {
    int          kind;   // 0 quiet, 1 load result, 2 illegal
    logic [4:0]  rd;
    logic [63:0] data;
    string       req;
    int          due;
  } item_t;

  item_t q[$];
  logic [7:0] model [MB];
  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] ld_i(logic [11:0] imm, logic [2:0] w, logic [4:0] rd);
    return {imm, 5'd0, w, rd, 7'h03};
  endfunction
  function automatic logic [31:0] st_i(logic [11:0] imm, logic [2:0] w);
    return {imm[11:5], 5'd0, 5'd0, w, imm[4:0], 7'h23};
  endfunction

  task automatic issue(logic [31:0] iw, logic [63:0] b, logic [63:0] wd, string req);
    item_t it;
    logic [11:0] off;
    logic [63:0] ta, v;
    int n;
    logic [2:0] w;
    @(negedge clk);
    req_valid = 1'b1; instr = iw; base = b; wdata = wd;
    w = iw[14:12];
    it.kind = 0; it.rd = iw[11:7]; it.data = '0; it.req = req; it.due = cyc + 1;
    if (iw[6:0] == 7'h03) begin
      off = iw[31:20];
      ta  = b + {{52{off[11]}}, off};
      if (w == 3'd7) it.kind = 2;
      else begin
        n = 1 << w[1:0];
        v = '0;
        for (int k = 0; k < n; k++) v[8*k +: 8] = model[(ta + k) % MB];
        if (!w[2] && n < 8) begin
          if (v[8*n-1]) for (int k = 8*n; k < 64; k++) v[k] = 1'b1;
        end
        it.kind = 1; it.data = v;
      end
    end else if (iw[6:0] == 7'h23) begin
      off = {iw[31:25], iw[11:7]};
      ta  = b + {{52{off[11]}}, off};
      if (w[2]) it.kind = 2;
      else begin
        n = 1 << w[1:0];
        for (int k = 0; k < n; k++) model[(ta + k) % MB] = wd[8*k +: 8];
      end
    end
    q.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        item_t it;
        it = q.pop_front();
        checks++;
        case (it.kind)
          1: if (!(rd_valid && !illegal && rd_idx == it.rd && rd_data == it.data)) begin
               fails++;
               $display("FAIL %s: valid=%0b ill=%0b idx=%0d data=%h, expected valid=1 ill=0 idx=%0d data=%h",
                        it.req, rd_valid, illegal, rd_idx, rd_data, it.rd, it.data);
             end
          2: if (!(illegal && !rd_valid)) begin
               fails++;
               $display("FAIL %s: valid=%0b ill=%0b, expected valid=0 ill=1", it.req, rd_valid, illegal);
             end
          default: if (rd_valid || illegal) begin
               fails++;
               $display("FAIL %s: valid=%0b ill=%0b, expected valid=0 ill=0", it.req, rd_valid, illegal);
             end
        endcase
      end else if (rd_valid || illegal) begin
        checks++; fails++;
        $display("FAIL R7: unexpected valid=%0b ill=%0b, expected both 0", rd_valid, illegal);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < MB; a++) model[a] = 8'h00;
    repeat (3) @(negedge clk);
    checks++;
    if (rd_valid || illegal) begin
      fails++;
      $display("FAIL R10: in reset valid=%0b ill=%0b, expected 0 0", rd_valid, illegal);
    end
    rst_n = 1'b1;
    idle(1);
    // R10: memory clear after reset
    issue(ld_i(12'd0, 3'd3, 5'd1), 64'd0, '0, "R10 zero memory");
    issue(ld_i(12'd0, 3'd3, 5'd2), 64'd200, '0, "R10 zero memory high");
    // R2 R5 R6: doubleword store then narrow reads
    issue(st_i(12'd0, 3'd3), 64'd16, 64'h8877665544332211, "R5 store dword");
    issue(ld_i(12'd0, 3'd0, 5'd3), 64'd16, '0, "R6 low byte first");
    issue(ld_i(12'd0, 3'd3, 5'd4), 64'd16, '0, "R6 dword order");
    issue(st_i(-12'sd4, 3'd0), 64'd24, 64'hFFFF_FFFF_FFFF_FFF0, "R2 negative store offset");
    issue(ld_i(12'd0, 3'd3, 5'd5), 64'd16, '0, "R5 only one byte changed");
    issue(ld_i(12'd4, 3'd2, 5'd6), 64'd16, '0, "R3 signed word");
    issue(ld_i(12'd4, 3'd6, 5'd7), 64'd16, '0, "R4 unsigned word");
    issue(ld_i(12'd6, 3'd1, 5'd8), 64'd16, '0, "R3 signed half");
    issue(ld_i(12'd6, 3'd5, 5'd9), 64'd16, '0, "R4 unsigned half");
    issue(ld_i(12'd7, 3'd0, 5'd10), 64'd16, '0, "R3 signed byte");
    issue(ld_i(12'd7, 3'd4, 5'd11), 64'd16, '0, "R4 unsigned byte");
    issue(ld_i(-12'sd24, 3'd1, 5'd12), 64'd40, '0, "R1 negative load offset");
    issue(ld_i(12'h7FF, 3'd0, 5'd13), 64'hFFFF_FFFF_FFFF_F811, '0, "R1 max offset");
    // R5: halfword and word stores leave neighbours alone
    issue(st_i(12'd30, 3'd1), 64'd0, 64'hFFFF_FFFF_FFFF_ABCD, "R5 store half");
    issue(st_i(12'd0, 3'd2), 64'd32, 64'h1234_5678_9ABC_DEF0, "R5 store word");
    issue(ld_i(12'd24, 3'd3, 5'd14), 64'd0, '0, "R5 half neighbours");
    issue(ld_i(12'd32, 3'd3, 5'd15), 64'd0, '0, "R5 word neighbours");
    // R8: illegal codes
    issue(st_i(12'd0, 3'd4), 64'd16, 64'hDEAD_BEEF_DEAD_BEEF, "R8 store code 4");
    issue(st_i(12'd0, 3'd7), 64'd16, 64'hDEAD_BEEF_DEAD_BEEF, "R8 store code 7");
    issue(ld_i(12'd0, 3'd7, 5'd16), 64'd16, '0, "R8 load code 7");
    issue(ld_i(12'd0, 3'd3, 5'd17), 64'd16, '0, "R8 memory untouched");
    // R7: other opcode, idle gap, back-to-back loads
    issue(32'h0630_0293, 64'd16, '0, "R7 other opcode quiet");
    idle(2);
    issue(ld_i(12'd0, 3'd2, 5'd18), 64'd16, '0, "R7 first of pair");
    issue(ld_i(12'd4, 3'd2, 5'd31), 64'd16, '0, "R7 second of pair");
    // R9: wrap at top of memory and high base bits
    issue(st_i(12'd0, 3'd3), 64'd252, 64'h0102_0304_0506_0708, "R9 wrapping store");
    issue(ld_i(12'd0, 3'd3, 5'd19), 64'd252, '0, "R9 wrapping load");
    issue(ld_i(12'd0, 3'd2, 5'd20), 64'd0, '0, "R9 wrapped bytes at 0");
    issue(ld_i(12'd0, 3'd3, 5'd21), 64'h1000_0000_0000_0010, '0, "R9 high base bits");
    issue(ld_i(12'd0, 3'd3, 5'd22), 64'd248, '0, "R9 below wrap point");
    idle(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule